// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block sits between a processor's instruction fetch port and a wide backing memory. It keeps a direct-mapped store of 256-bit lines, each holding eight 32-bit instructions. A fetch that finds its line present returns the instruction one cycle after it is accepted. A fetch that misses sends one line-aligned request to the backing memory and takes the whole line back in a single wide transfer after a fixed latency. The fetch completes two cycles later than a hit would have.

A 3-bit mode input controls how misses treat the store. The normal modes fill on a miss. The hold mode still serves hits but leaves the store untouched on a miss. The pass-through mode, and every reserved code, makes each fetch a miss and never fills. A two-register bus lets software drop a byte range from the cache after it changes program memory. One register holds a start address and the other holds a word count. Writing a non-zero count starts the clear. The count reads back as zero once every line that overlaps the range has been cleared.

Top module: `icache_ctrl`

## Requirements
- R1: A fetch accepted while `fetch_ready` is high, whose line is valid with a matching tag in a filling or hold mode, raises `mem_req` low in that cycle and returns `fetch_valid` with the data in the next cycle.
- R2: A missing fetch raises `mem_req` in its acceptance cycle with `mem_addr` equal to the fetch address with its low 5 bits cleared. It expects `mem_line` two cycles later and returns `fetch_valid` three cycles after acceptance. `fetch_ready` stays low in between.
- R3: Address bits [4:2] select the returned word: value w returns `mem_line[32*w+31:32*w]`, on a hit as well as on a miss.
- R4: Mode codes 3'b000 and 3'b010 fill on a miss, so a later fetch anywhere in that line hits. It also returns the stored data even if the backing memory has since changed.
- R5: Mode 3'b011 serves hits normally, but a miss changes no line, tag or valid bit.
- R6: Mode 3'b100 treats every fetch as a miss and changes no stored state.
- R7: The reserved codes 3'b001, 3'b101, 3'b110 and 3'b111 behave exactly like 3'b100.
- R8: Reset clears every valid bit, so the first fetch of any line after reset misses. After reset `fetch_valid` and `mem_req` are low, `fetch_ready` is high and the control register reads 0.
- R9: Register offset 0x0 holds the invalidate start address and reads back. Offset 0x4 is the control register: bits [15:0] hold the word count and bit 31 reads 1 while invalidation is busy.
- R10: Writing a non-zero count clears the valid bit of every line that overlaps bytes [start, start + 4*count), capped at the whole store. Lines outside that range keep their contents.
- R11: While the count is non-zero, `fetch_ready` stays low and writes to either register are ignored. The count returns to 0 when the clear is finished.
- R12: Writing a count of 0 starts nothing. The block stays ready and no line is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Cache mode, sampled when a fetch is accepted |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_ready | output | 1 | Block can accept a fetch this cycle |
| fetch_valid | output | 1 | Returned instruction is valid |
| fetch_data | output | 32 | Returned instruction |
| mem_req | output | 1 | Line request to backing memory |
| mem_addr | output | 32 | Line-aligned request address |
| mem_line | input | 256 | Line from backing memory, valid two cycles after the request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions watch the cycle-level handshake on every cycle. They check that an accepted hit is answered on the next cycle, that a miss stalls the port and is not answered on the next cycle, and that the pass-through and reserved codes always issue a memory request. They also check that no fetch result appears while lines are being cleared. The bench scenarios are what show the data-dependent behaviour: which word is selected, whether a miss really filled, and whether the hold and pass-through modes left lines untouched. To expose a fill, the bench changes the backing memory and looks for stale data. The scenarios also show exactly which lines a range clear removes and that register writes during a clear are dropped.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } fetch_state_e;

   localparam logic [2:0] MODE_ON_LEGACY = 3'b000;
   localparam logic [2:0] MODE_ON        = 3'b010;
   localparam logic [2:0] MODE_HOLD      = 3'b011;
   localparam logic [2:0] MODE_PASS      = 3'b100;

endpackage

// File: rtl/icache_mode_dec.sv
module icache_mode_dec
   import icache_pkg::*;
(
   input  logic [2:0] mode_i,
   output logic       fill_o,
   output logic       force_miss_o
);

   always_comb begin
      unique case (mode_i)
         MODE_ON_LEGACY, MODE_ON: begin
            fill_o       = 1'b1;
            force_miss_o = 1'b0;
         end
         MODE_HOLD: begin
            fill_o       = 1'b0;
            force_miss_o = 1'b0;
         end
         default: begin
            // pass-through and all reserved codes
            fill_o       = 1'b0;
            force_miss_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/icache_word_sel.sv
module icache_word_sel #(
   parameter int LINE_BITS = 256,
   parameter int WORD_W    = 32,
   parameter int SEL_W     = $clog2(LINE_BITS / WORD_W)
) (
   input  logic [LINE_BITS-1:0] line_i,
   input  logic [SEL_W-1:0]     sel_i,
   output logic [WORD_W-1:0]    word_o
);

   localparam int NWORDS = LINE_BITS / WORD_W;

   logic [WORD_W-1:0] words [NWORDS];

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      assign words[g] = line_i[g*WORD_W +: WORD_W];
   end

   assign word_o = words[sel_i];

endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
   parameter int NUM_LINES = 1024,
   parameter int IDX_W     = 10,
   parameter int TAG_W     = 17,
   parameter int LINE_BITS = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx_i,
   output logic                 rd_valid_o,
   output logic [TAG_W-1:0]     rd_tag_o,
   output logic [LINE_BITS-1:0] rd_line_o,
   input  logic                 fill_en_i,
   input  logic [IDX_W-1:0]     fill_idx_i,
   input  logic [TAG_W-1:0]     fill_tag_i,
   input  logic [LINE_BITS-1:0] fill_line_i,
   input  logic                 inv_en_i,
   input  logic [IDX_W-1:0]     inv_idx_i
);

   logic [NUM_LINES-1:0] valid_q;
   logic [TAG_W-1:0]     tag_q  [NUM_LINES];
   logic [LINE_BITS-1:0] data_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         if (inv_en_i)  valid_q[inv_idx_i]  <= 1'b0;
         if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en_i) begin
         tag_q[fill_idx_i]  <= fill_tag_i;
         data_q[fill_idx_i] <= fill_line_i;
      end
   end

   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_tag_o   = tag_q[rd_idx_i];
   assign rd_line_o  = data_q[rd_idx_i];

endmodule

// File: rtl/icache_inval_eng.sv
module icache_inval_eng #(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 5,
   parameter int IDX_W     = 10,
   parameter int NUM_LINES = 1024,
   parameter int CNT_W     = 16,
   parameter int REG_AW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [ADDR_W-1:0] reg_wdata_i,
   output logic [ADDR_W-1:0] reg_rdata_o,
   input  logic              fsm_idle_i,
   output logic              busy_o,
   output logic              inv_en_o,
   output logic [IDX_W-1:0]  inv_idx_o
);

   localparam int SPAN_W = ADDR_W - OFF_W;
   localparam int LEFT_W = IDX_W + 1;
   localparam logic [REG_AW-1:0] OFS_START = REG_AW'(0);
   localparam logic [REG_AW-1:0] OFS_CTRL  = REG_AW'(4);

   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  count_q;
   logic              run_q;
   logic [IDX_W-1:0]  cur_q;
   logic [LEFT_W-1:0] left_q;

   logic              wr_ok;
   logic [ADDR_W-1:0] byte_len;
   logic [ADDR_W-1:0] last_addr;
   logic [SPAN_W-1:0] span;
   logic [LEFT_W-1:0] left_init;

   assign busy_o    = (count_q != '0);
   assign wr_ok     = reg_wr_i && !busy_o;
   assign byte_len  = ADDR_W'({count_q, 2'b00});
   assign last_addr = start_q + byte_len - ADDR_W'(1);
   assign span      = last_addr[ADDR_W-1:OFF_W] - start_q[ADDR_W-1:OFF_W] + SPAN_W'(1);
   assign left_init = (span > SPAN_W'(NUM_LINES)) ? LEFT_W'(NUM_LINES) : LEFT_W'(span);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         count_q <= '0;
         run_q   <= 1'b0;
         cur_q   <= '0;
         left_q  <= '0;
      end else begin
         if (wr_ok && reg_addr_i == OFS_START) start_q <= reg_wdata_i;
         if (wr_ok && reg_addr_i == OFS_CTRL)  count_q <= reg_wdata_i[CNT_W-1:0];
         if (!run_q && busy_o && fsm_idle_i) begin
            run_q  <= 1'b1;
            cur_q  <= start_q[OFF_W +: IDX_W];
            left_q <= left_init;
         end else if (run_q) begin
            cur_q  <= cur_q + IDX_W'(1);
            left_q <= left_q - LEFT_W'(1);
            if (left_q == LEFT_W'(1)) begin
               run_q   <= 1'b0;
               count_q <= '0;
            end
         end
      end
   end

   assign inv_en_o  = run_q;
   assign inv_idx_o = cur_q;

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == OFS_START) begin
         reg_rdata_o = start_q;
      end else if (reg_addr_i == OFS_CTRL) begin
         reg_rdata_o[ADDR_W-1]  = busy_o;
         reg_rdata_o[CNT_W-1:0] = count_q;
      end
   end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
   import icache_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_BITS = 256,
   parameter int NUM_LINES = 1024,
   parameter int MISS_LAT  = 2,
   parameter int CNT_W     = 16,
   parameter int REG_AW    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           mode_sel,
   input  logic                 fetch_req,
   input  logic [ADDR_W-1:0]    fetch_addr,
   output logic                 fetch_ready,
   output logic                 fetch_valid,
   output logic [31:0]          fetch_data,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic [LINE_BITS-1:0] mem_line,
   input  logic                 reg_wr,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [ADDR_W-1:0]    reg_wdata,
   output logic [ADDR_W-1:0]    reg_rdata
);

   localparam int OFF_W  = $clog2(LINE_BITS / 8);
   localparam int SEL_W  = $clog2(LINE_BITS / 32);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int SPAN_W = ADDR_W - OFF_W;
   localparam int LAT_W  = $clog2(MISS_LAT + 1);

   if (LINE_BITS < 64 || (LINE_BITS & (LINE_BITS - 1)) != 0) begin : g_bad_line
      $error("LINE_BITS must be a power of two of at least 64");
   end
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (MISS_LAT < 1) begin : g_bad_lat
      $error("MISS_LAT must be at least 1");
   end
   if (CNT_W + 2 > ADDR_W || TAG_W < 1) begin : g_bad_widths
      $error("address width too small for count or tag");
   end

   fetch_state_e          state_q;
   logic [LAT_W-1:0]      wait_q;
   logic [SPAN_W-1:0]     pend_line_q;
   logic [SEL_W-1:0]      pend_sel_q;
   logic                  pend_fill_q;

   logic                  fill_mode, force_miss;
   logic                  s_valid;
   logic [TAG_W-1:0]      s_tag;
   logic [LINE_BITS-1:0]  s_line;
   logic [31:0]           hit_word, mem_word;
   logic                  hit, accept, fill_we, inv_busy, inv_en;
   logic [IDX_W-1:0]      inv_idx;
   logic [1:0]            unused_byte_bits;

   assign unused_byte_bits = fetch_addr[1:0];

   icache_mode_dec i_mode (
      .mode_i       (mode_sel),
      .fill_o       (fill_mode),
      .force_miss_o (force_miss)
   );

   icache_line_store #(
      .NUM_LINES (NUM_LINES), .IDX_W (IDX_W), .TAG_W (TAG_W), .LINE_BITS (LINE_BITS)
   ) i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx_i    (fetch_addr[OFF_W +: IDX_W]),
      .rd_valid_o  (s_valid),
      .rd_tag_o    (s_tag),
      .rd_line_o   (s_line),
      .fill_en_i   (fill_we),
      .fill_idx_i  (pend_line_q[IDX_W-1:0]),
      .fill_tag_i  (pend_line_q[SPAN_W-1 -: TAG_W]),
      .fill_line_i (mem_line),
      .inv_en_i    (inv_en),
      .inv_idx_i   (inv_idx)
   );

   icache_word_sel #(.LINE_BITS (LINE_BITS), .WORD_W (32), .SEL_W (SEL_W)) i_hit_sel (
      .line_i (s_line),
      .sel_i  (fetch_addr[2 +: SEL_W]),
      .word_o (hit_word)
   );

   icache_word_sel #(.LINE_BITS (LINE_BITS), .WORD_W (32), .SEL_W (SEL_W)) i_mem_sel (
      .line_i (mem_line),
      .sel_i  (pend_sel_q),
      .word_o (mem_word)
   );

   icache_inval_eng #(
      .ADDR_W (ADDR_W), .OFF_W (OFF_W), .IDX_W (IDX_W),
      .NUM_LINES (NUM_LINES), .CNT_W (CNT_W), .REG_AW (REG_AW)
   ) i_inval (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .fsm_idle_i  (state_q == ST_IDLE),
      .busy_o      (inv_busy),
      .inv_en_o    (inv_en),
      .inv_idx_o   (inv_idx)
   );

   assign fetch_ready = (state_q == ST_IDLE) && !inv_busy;
   assign accept      = fetch_req && fetch_ready;
   assign hit         = s_valid && (s_tag == fetch_addr[ADDR_W-1 -: TAG_W]) && !force_miss;
   assign mem_req     = accept && !hit;
   assign mem_addr    = {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign fill_we     = (state_q == ST_FILL) && (wait_q == '0) && pend_fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         wait_q      <= '0;
         pend_line_q <= '0;
         pend_sel_q  <= '0;
         pend_fill_q <= 1'b0;
         fetch_valid <= 1'b0;
         fetch_data  <= '0;
      end else begin
         fetch_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept && hit) begin
                  fetch_valid <= 1'b1;
                  fetch_data  <= hit_word;
               end else if (accept) begin
                  state_q     <= ST_FILL;
                  wait_q      <= LAT_W'(MISS_LAT - 1);
                  pend_line_q <= fetch_addr[ADDR_W-1:OFF_W];
                  pend_sel_q  <= fetch_addr[2 +: SEL_W];
                  pend_fill_q <= fill_mode;
               end
            end
            ST_FILL: begin
               if (wait_q == '0) begin
                  fetch_valid <= 1'b1;
                  fetch_data  <= mem_word;
                  state_q     <= ST_IDLE;
               end else begin
                  wait_q <= wait_q - LAT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
   parameter int MISS_LAT = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_sel,
   input logic       fetch_req,
   input logic       fetch_ready,
   input logic       fetch_valid,
   input logic       mem_req,
   input logic       inv_en
);

   // R1
   hit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ready && !mem_req) |=> fetch_valid);

   // R2
   miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !fetch_ready);

   if (MISS_LAT > 1) begin : g_late
      // R2
      miss_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_req |=> !fetch_valid);
   end

   // R6 R7
   force_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ready && !(mode_sel inside {3'b000, 3'b010, 3'b011})) |-> mem_req);

   // R11
   inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |-> !fetch_valid);

endmodule

bind icache_ctrl icache_ctrl_chk #(.MISS_LAT (MISS_LAT)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sel    (mode_sel),
   .fetch_req   (fetch_req),
   .fetch_ready (fetch_ready),
   .fetch_valid (fetch_valid),
   .mem_req     (mem_req),
   .inv_en      (inv_en)
);

// File: tb/test_icache_ctrl.sv
`timescale 1ns/1ps
module test_icache_ctrl;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   mode_sel = 3'b000;
   logic         fetch_req = 1'b0;
   logic [31:0]  fetch_addr = '0;
   logic         fetch_ready, fetch_valid, mem_req;
   logic [31:0]  fetch_data, mem_addr, reg_rdata;
   logic [255:0] mem_line;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;

   int checks = 0;
   int failures = 0;
   logic [7:0]  gen = 8'd1;
   logic [31:0] a1 = '0, a2 = '0;

   always #2 clk = ~clk;

   icache_ctrl i_icache_ctrl (
      .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
      .fetch_req (fetch_req), .fetch_addr (fetch_addr), .fetch_ready (fetch_ready),
      .fetch_valid (fetch_valid), .fetch_data (fetch_data),
      .mem_req (mem_req), .mem_addr (mem_addr), .mem_line (mem_line),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
   );

   function automatic logic [31:0] exp_word(input logic [31:0] a, input logic [7:0] g);
      return {g, 2'b00, a[23:2]};
   endfunction

   // backing memory: line valid two cycles after the request
   always @(posedge clk) begin
      a1 <= mem_addr;
      a2 <= a1;
   end
   always_comb begin
      for (int w = 0; w < 8; w++) mem_line[w*32 +: 32] = {gen, 2'b00, a2[23:5], 3'(w)};
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [31:0] a, input logic [2:0] m,
                           output logic [31:0] d, output int lat, output bit miss);
      int guard;
      @(negedge clk);
      mode_sel = m; fetch_addr = a; fetch_req = 1'b1;
      #1;
      guard = 0;
      while (!fetch_ready && guard < 5000) begin
         @(negedge clk); #1; guard++;
      end
      miss = mem_req;
      @(posedge clk); #1;
      fetch_req = 1'b0;
      lat = 1;
      while (!fetch_valid && lat < 50) begin
         @(posedge clk); #1; lat++;
      end
      d = fetch_data;
   endtask

   task automatic reg_write(input logic [2:0] ad, input logic [31:0] dt);
      @(negedge clk);
      reg_addr = ad; reg_wdata = dt; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] ad, output logic [31:0] dt);
      @(negedge clk);
      reg_addr = ad;
      #1 dt = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      int guard = 0;
      reg_read(3'd4, v);
      while (v != 0 && guard < 5000) begin
         reg_read(3'd4, v);
         guard++;
      end
   endtask

   // fields: [35:33] mode, [32:1] address, [0] expected miss
   localparam logic [35:0] VEC [16] = '{
      {3'b000, 32'h0000_0100, 1'b1},  // R8 first fetch after reset misses
      {3'b000, 32'h0000_0104, 1'b0},  // R4 filled line hits
      {3'b000, 32'h0000_011C, 1'b0},  // R3 last word of the line
      {3'b010, 32'h0000_0120, 1'b1},  // R4 second enable code fills
      {3'b010, 32'h0000_013C, 1'b0},  // R4
      {3'b011, 32'h0000_0200, 1'b1},  // R5 hold-mode miss
      {3'b011, 32'h0000_0200, 1'b1},  // R5 no fill happened
      {3'b011, 32'h0000_0108, 1'b0},  // R5 hits still served
      {3'b100, 32'h0000_0100, 1'b1},  // R6 forced miss on cached line
      {3'b100, 32'h0000_0300, 1'b1},  // R6
      {3'b000, 32'h0000_0300, 1'b1},  // R6 pass-through did not fill
      {3'b001, 32'h0000_0304, 1'b1},  // R7 reserved code forces miss
      {3'b111, 32'h0000_0120, 1'b1},  // R7
      {3'b000, 32'h0000_0104, 1'b0},  // R6 R7 contents kept
      {3'b000, 32'h0000_8100, 1'b1},  // R4 same index, other tag
      {3'b000, 32'h0000_0100, 1'b1}   // R4 evicted by conflict
   };

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired (R11 completion) actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d, v;
      int lat;
      bit miss;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R8 reset state
      check(fetch_valid == 1'b0 && mem_req == 1'b0, "R8 outputs after reset", {fetch_valid, mem_req}, 0);
      check(fetch_ready == 1'b1, "R8 ready after reset", fetch_ready, 1);
      reg_read(3'd4, v);
      check(v == 0, "R8 control after reset", v, 0);

      foreach (VEC[i]) begin
         do_fetch(VEC[i][32:1], VEC[i][35:33], d, lat, miss);
         check(miss == VEC[i][0], $sformatf("R1 R2 hit/miss row %0d", i), miss, VEC[i][0]);
         check(lat == (VEC[i][0] ? 3 : 1), $sformatf("R2 latency row %0d", i), lat, VEC[i][0] ? 3 : 1);
         check(d == exp_word(VEC[i][32:1], gen), $sformatf("R3 data row %0d", i), d, exp_word(VEC[i][32:1], gen));
      end

      // R4: memory changes, cached line still returns the filled data
      gen = 8'd2;
      do_fetch(32'h108, 3'b000, d, lat, miss);
      check(!miss && d == exp_word(32'h108, 8'd1), "R4 stale data proves fill", d, exp_word(32'h108, 8'd1));
      do_fetch(32'h140, 3'b000, d, lat, miss);
      check(miss && d == exp_word(32'h140, 8'd2), "R2 miss fetch", d, exp_word(32'h140, 8'd2));

      // R9 register access
      reg_write(3'd0, 32'h0000_0104);
      reg_read(3'd0, v);
      check(v == 32'h104, "R9 start readback", v, 32'h104);

      // R10 R11 range clear of lines 0x100 and 0x120
      reg_write(3'd4, 32'd9);
      reg_read(3'd4, v);
      check(v == 32'h8000_0009, "R9 R11 busy and count", v, 32'h8000_0009);
      check(fetch_ready == 1'b0, "R11 stall while busy", fetch_ready, 0);
      wait_idle();
      reg_read(3'd4, v);
      check(v == 0, "R11 count cleared", v, 0);
      do_fetch(32'h100, 3'b000, d, lat, miss);
      check(miss && d == exp_word(32'h100, 8'd2), "R10 first line cleared", d, exp_word(32'h100, 8'd2));
      do_fetch(32'h124, 3'b000, d, lat, miss);
      check(miss == 1'b1, "R10 last line cleared", miss, 1);
      do_fetch(32'h144, 3'b000, d, lat, miss);
      check(miss == 1'b0, "R10 next line kept", miss, 0);
      do_fetch(32'h300, 3'b000, d, lat, miss);
      check(!miss && d == exp_word(32'h300, 8'd1), "R10 far line kept", d, exp_word(32'h300, 8'd1));

      // R12 zero count
      reg_write(3'd4, 32'd0);
      reg_read(3'd4, v);
      check(v == 0 && fetch_ready, "R12 no busy on zero count", v, 0);
      do_fetch(32'h300, 3'b000, d, lat, miss);
      check(miss == 1'b0, "R12 nothing cleared", miss, 0);

      // R10 cap at whole store, R11 writes ignored while busy
      reg_write(3'd0, 32'h0);
      reg_write(3'd4, 32'h0000_FFFF);
      reg_write(3'd0, 32'hDEAD_0000);
      reg_write(3'd4, 32'h0000_0001);
      wait_idle();
      reg_read(3'd0, v);
      check(v == 32'h0, "R11 start write ignored", v, 0);
      do_fetch(32'h140, 3'b000, d, lat, miss);
      check(miss == 1'b1, "R10 full clear", miss, 1);
      do_fetch(32'h300, 3'b000, d, lat, miss);
      check(miss && d == exp_word(32'h300, 8'd2), "R10 full clear far line", d, exp_word(32'h300, 8'd2));
      do_fetch(32'h304, 3'b000, d, lat, miss);
      check(miss == 1'b0, "R4 refill after clear", miss, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule